// File: doc/BRIEF.md
# Posted Interrupt Bitmap Merger

This block keeps a 64-byte posted-interrupt descriptor in local registers and merges its pending-vector bitmap into a virtual CPU's interrupt request register. Interrupt sources post vectors through an atomic set-bit stream. Each post sets one bitmap bit and raises the outstanding-notification flag. A notification request goes out only when the flag goes from clear to set, so several posts that arrive close together share one notification.

Notifications come back on an input stream. If the vector matches the configured notification vector and the virtual CPU is running, the block clears the outstanding flag. It then sweeps the bitmap one 32-bit word per handshake and hands each word to the virtual controller on a merge stream, where it is ORed into the request register. Each word is cleared in the same cycle it is handed over. If the virtual CPU is not running, the notification is recorded and the sweep starts once the CPU runs again. A notification with any other vector goes out unchanged on a pass-through stream.

Stream rules: a transfer happens on a clock edge where valid and ready are both high. The merge stream holds its word index while ready is low. The post stream is always ready. The incoming notification stream takes its ready from pass-through back-pressure for foreign vectors, and from sweep idleness for the notification vector.

Top module: `posted_intr_merge`

## Requirements
- R1: After reset all bitmap words and the outstanding flag read zero, and mrg_valid, irq_out_valid and notify_req are low.
- R2: An accepted post of vector N sets bit N mod 32 of descriptor word N/32 and sets the outstanding flag at bit 0 of descriptor word 8. post_ready is always high.
- R3: notify_req pulses high for one cycle, in the cycle after an accepted post, only when the outstanding flag was clear before that post or was cleared by a sweep starting in the same cycle.
- R4: A notification-vector match accepted while vcpu_running is high clears the outstanding flag and starts a sweep. The sweep presents words 0 to 7 in order on the merge stream, each word carrying its bitmap bits, and the block then goes idle.
- R5: A bitmap word is cleared in the cycle its merge handshake occurs. After an undisturbed sweep all bitmap words read zero.
- R6: While mrg_ready is low, mrg_valid stays high and mrg_index does not change. The sweep moves forward only on a handshake.
- R7: A post that lands during a sweep is never lost. A post to a word not yet handed over appears in that word's merge. A post to a word already handed over, or handed over in the same cycle, stays set in the bitmap.
- R8: A matching notification accepted while vcpu_running is low leaves the descriptor untouched and starts no sweep. The sweep starts on the first edge where vcpu_running is high.
- R9: A notification with a vector other than cfg_nv appears on irq_out_vector with irq_out_valid high, and irq_in_ready equals irq_out_ready. The descriptor and merge stream are unaffected.
- R10: While a sweep is in progress, a matching notification sees irq_in_ready low and no second sweep starts.
- R11: Descriptor writes replace bitmap words 0 to 7. For word 8 only bit 0 is stored, and words 9 to 15 keep nothing. Reserved bits and words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nv | input | 8 | Configured notification vector |
| vcpu_running | input | 1 | Virtual CPU currently executing |
| post_valid | input | 1 | Post request valid |
| post_ready | output | 1 | Post request accepted (always high) |
| post_vector | input | 8 | Vector to post |
| notify_req | output | 1 | One-cycle request to send a notification |
| irq_in_valid | input | 1 | Incoming notification valid |
| irq_in_ready | output | 1 | Incoming notification accepted |
| irq_in_vector | input | 8 | Incoming notification vector |
| irq_out_valid | output | 1 | Pass-through interrupt valid |
| irq_out_ready | input | 1 | Pass-through interrupt accepted |
| irq_out_vector | output | 8 | Pass-through interrupt vector |
| mrg_valid | output | 1 | Merge word valid |
| mrg_ready | input | 1 | Virtual controller takes the merge word |
| mrg_index | output | 3 | Bitmap word index being merged |
| mrg_bits | output | 32 | Bitmap bits to OR into the request register |
| desc_wr_en | input | 1 | Descriptor word write strobe |
| desc_wr_addr | input | 4 | Descriptor word address |
| desc_wr_data | input | 32 | Descriptor write data |
| desc_rd_addr | input | 4 | Descriptor read word address |
| desc_rd_data | output | 32 | Descriptor read data |

## Verification
The bench builds the block with its defaults: 256 vectors in 32-bit words, which gives an eight-word sweep and a 16-word descriptor. With these values vector 255 lands at bit 31 of the last word, and vectors 33 and 40 share word 1. The stalls on the merge stream can then hold the sweep on a chosen word while posts land just before and just after it. The notification vector is set to 0xF2, so foreign vectors on either side of it check the pass-through path.

// File: rtl/pim_pkg.sv
package pim_pkg;
  typedef enum logic {
    SW_IDLE = 1'b0,
    SW_RUN  = 1'b1
  } sweep_state_e;

  localparam int DESC_BYTES = 64;
endpackage

// File: rtl/pim_store.sv
module pim_store #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 post_fire,
  input  logic [$clog2(NUM_VEC)-1:0]           post_vec,
  input  logic                                 wr_en,
  input  logic [$clog2(2*NUM_VEC/WORD_W)-1:0]  wr_addr,
  input  logic [WORD_W-1:0]                    wr_data,
  input  logic [$clog2(2*NUM_VEC/WORD_W)-1:0]  rd_addr,
  output logic [WORD_W-1:0]                    rd_data,
  input  logic                                 clr_en,
  input  logic [$clog2(NUM_VEC/WORD_W)-1:0]    clr_idx,
  input  logic                                 on_clear,
  input  logic [$clog2(NUM_VEC/WORD_W)-1:0]    sel_idx,
  output logic [WORD_W-1:0]                    sel_word,
  output logic                                 on_q,
  output logic                                 notify_q
);
  localparam int NWORDS = NUM_VEC / WORD_W;
  localparam int DWORDS = 2 * NUM_VEC / WORD_W;
  localparam int VEC_W  = $clog2(NUM_VEC);
  localparam int IDX_W  = $clog2(NWORDS);
  localparam int BIT_W  = $clog2(WORD_W);
  localparam int ADDR_W = $clog2(DWORDS);

  logic [WORD_W-1:0] bm [NWORDS];
  logic              on_eff;
  logic              on_nxt;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    logic [WORD_W-1:0] q;
    logic [WORD_W-1:0] nxt;
    always_comb begin
      nxt = q;
      if (clr_en && clr_idx == IDX_W'(w)) nxt = '0;
      if (wr_en && wr_addr == ADDR_W'(w)) nxt = wr_data;
      if (post_fire && post_vec[VEC_W-1:BIT_W] == IDX_W'(w))
        nxt[post_vec[BIT_W-1:0]] = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
    end
    assign bm[w] = q;
  end

  assign sel_word = bm[sel_idx];

  always_comb begin
    on_eff = on_q && !on_clear;
    on_nxt = on_eff;
    if (wr_en && wr_addr == ADDR_W'(NWORDS)) on_nxt = wr_data[0];
    if (post_fire) on_nxt = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q     <= 1'b0;
      notify_q <= 1'b0;
    end else begin
      on_q     <= on_nxt;
      notify_q <= post_fire && !on_eff;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr < ADDR_W'(NWORDS))       rd_data = bm[rd_addr[IDX_W-1:0]];
    else if (rd_addr == ADDR_W'(NWORDS)) rd_data[0] = on_q;
  end

  AST_NOTIFY_NEEDS_POST: assert property (@(posedge clk) disable iff (!rst_n)
    notify_q |-> $past(post_fire)); // R3
  AST_POST_SETS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    post_fire |=> on_q); // R2
  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr > ADDR_W'(NWORDS)) |-> (rd_data == '0)); // R11
  AST_SWEPT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(post_fire && post_vec[VEC_W-1:BIT_W] == clr_idx)
            && !(wr_en && wr_addr == ADDR_W'(clr_idx)))
    |=> (bm[$past(clr_idx)] == '0)); // R5
endmodule

// File: rtl/pim_sweep.sv
module pim_sweep
  import pim_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [WORD_W-1:0]                  word_in,
  output logic                               mrg_valid,
  input  logic                               mrg_ready,
  output logic [$clog2(NUM_VEC/WORD_W)-1:0]  mrg_index,
  output logic [WORD_W-1:0]                  mrg_bits,
  output logic                               busy,
  output logic                               clr_en
);
  localparam int NWORDS = NUM_VEC / WORD_W;
  localparam int IDX_W  = $clog2(NWORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  sweep_state_e     state_q;
  logic [IDX_W-1:0] idx_q;

  assign busy      = (state_q == SW_RUN);
  assign mrg_valid = busy;
  assign mrg_index = idx_q;
  assign mrg_bits  = word_in;
  assign clr_en    = mrg_valid && mrg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SW_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        SW_IDLE: if (start) begin
          state_q <= SW_RUN;
          idx_q   <= '0;
        end
        SW_RUN: if (clr_en) begin
          if (idx_q == LAST_IDX) begin
            state_q <= SW_IDLE;
            idx_q   <= '0;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= SW_IDLE;
      endcase
    end
  end

  AST_MRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrg_valid && !mrg_ready) |=> (mrg_valid && $stable(mrg_index))); // R6
  AST_SWEEP_ENDS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mrg_index) == LAST_IDX)); // R4
endmodule

// File: rtl/pim_route.sv
module pim_route #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VEC_W-1:0] cfg_nv,
  input  logic             vcpu_running,
  input  logic             busy,
  input  logic             irq_in_valid,
  output logic             irq_in_ready,
  input  logic [VEC_W-1:0] irq_in_vector,
  output logic             irq_out_valid,
  input  logic             irq_out_ready,
  output logic [VEC_W-1:0] irq_out_vector,
  output logic             start
);
  logic match;
  logic acc_match;
  logic deferred_q;

  assign match          = (irq_in_vector == cfg_nv);
  assign irq_out_valid  = irq_in_valid && !match;
  assign irq_out_vector = irq_in_vector;
  assign irq_in_ready   = match ? !busy : irq_out_ready;
  assign acc_match      = irq_in_valid && match && !busy;
  assign start          = !busy && vcpu_running && (acc_match || deferred_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          deferred_q <= 1'b0;
    else if (start)                      deferred_q <= 1'b0;
    else if (acc_match && !vcpu_running) deferred_q <= 1'b1;
  end

  AST_DEFER_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !vcpu_running |-> !start); // R8
endmodule

// File: rtl/posted_intr_merge.sv
module posted_intr_merge #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [$clog2(NUM_VEC)-1:0]          cfg_nv,
  input  logic                                vcpu_running,
  input  logic                                post_valid,
  output logic                                post_ready,
  input  logic [$clog2(NUM_VEC)-1:0]          post_vector,
  output logic                                notify_req,
  input  logic                                irq_in_valid,
  output logic                                irq_in_ready,
  input  logic [$clog2(NUM_VEC)-1:0]          irq_in_vector,
  output logic                                irq_out_valid,
  input  logic                                irq_out_ready,
  output logic [$clog2(NUM_VEC)-1:0]          irq_out_vector,
  output logic                                mrg_valid,
  input  logic                                mrg_ready,
  output logic [$clog2(NUM_VEC/WORD_W)-1:0]   mrg_index,
  output logic [WORD_W-1:0]                   mrg_bits,
  input  logic                                desc_wr_en,
  input  logic [$clog2(2*NUM_VEC/WORD_W)-1:0] desc_wr_addr,
  input  logic [WORD_W-1:0]                   desc_wr_data,
  input  logic [$clog2(2*NUM_VEC/WORD_W)-1:0] desc_rd_addr,
  output logic [WORD_W-1:0]                   desc_rd_data
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int IDX_W = $clog2(NUM_VEC / WORD_W);

  logic              post_fire;
  logic              start;
  logic              busy;
  logic              clr_en;
  logic              on_q;
  logic [WORD_W-1:0] sel_word;
  logic [IDX_W-1:0]  idx;

  assign post_ready = 1'b1;
  assign post_fire  = post_valid && post_ready;
  assign mrg_index  = idx;

  pim_route #(.VEC_W(VEC_W)) u_route (
    .clk(clk), .rst_n(rst_n), .cfg_nv(cfg_nv), .vcpu_running(vcpu_running),
    .busy(busy), .irq_in_valid(irq_in_valid), .irq_in_ready(irq_in_ready),
    .irq_in_vector(irq_in_vector), .irq_out_valid(irq_out_valid),
    .irq_out_ready(irq_out_ready), .irq_out_vector(irq_out_vector),
    .start(start)
  );

  pim_sweep #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(start), .word_in(sel_word),
    .mrg_valid(mrg_valid), .mrg_ready(mrg_ready), .mrg_index(idx),
    .mrg_bits(mrg_bits), .busy(busy), .clr_en(clr_en)
  );

  pim_store #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst_n(rst_n), .post_fire(post_fire), .post_vec(post_vector),
    .wr_en(desc_wr_en), .wr_addr(desc_wr_addr), .wr_data(desc_wr_data),
    .rd_addr(desc_rd_addr), .rd_data(desc_rd_data),
    .clr_en(clr_en), .clr_idx(idx), .on_clear(start),
    .sel_idx(idx), .sel_word(sel_word), .on_q(on_q), .notify_q(notify_req)
  );

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start); // R10
  AST_START_CLEARS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !post_fire && !desc_wr_en) |=> !on_q); // R4
endmodule

// File: tb/posted_intr_merge_tb_top.sv
module posted_intr_merge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] NV = 8'hF2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_nv = NV;
  logic        vcpu_running = 1'b1;
  logic        post_valid = 1'b0;
  logic        post_ready;
  logic [7:0]  post_vector = '0;
  logic        notify_req;
  logic        irq_in_valid = 1'b0;
  logic        irq_in_ready;
  logic [7:0]  irq_in_vector = '0;
  logic        irq_out_valid;
  logic        irq_out_ready = 1'b1;
  logic [7:0]  irq_out_vector;
  logic        mrg_valid;
  logic        mrg_ready = 1'b1;
  logic [2:0]  mrg_index;
  logic [31:0] mrg_bits;
  logic        desc_wr_en = 1'b0;
  logic [3:0]  desc_wr_addr = '0;
  logic [31:0] desc_wr_data = '0;
  logic [3:0]  desc_rd_addr = '0;
  logic [31:0] desc_rd_data;

  int checks = 0;
  int fails  = 0;
  logic [34:0] exp_q[$];
  logic [31:0] rd_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  posted_intr_merge dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_nv(cfg_nv), .vcpu_running(vcpu_running),
    .post_valid(post_valid), .post_ready(post_ready), .post_vector(post_vector),
    .notify_req(notify_req), .irq_in_valid(irq_in_valid), .irq_in_ready(irq_in_ready),
    .irq_in_vector(irq_in_vector), .irq_out_valid(irq_out_valid),
    .irq_out_ready(irq_out_ready), .irq_out_vector(irq_out_vector),
    .mrg_valid(mrg_valid), .mrg_ready(mrg_ready), .mrg_index(mrg_index),
    .mrg_bits(mrg_bits), .desc_wr_en(desc_wr_en), .desc_wr_addr(desc_wr_addr),
    .desc_wr_data(desc_wr_data), .desc_rd_addr(desc_rd_addr), .desc_rd_data(desc_rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: the handshake seen here completes at the following rising edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && mrg_valid && mrg_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 unexpected merge", {29'd0, mrg_index, mrg_bits}, 64'd0);
      else begin
        logic [34:0] e;
        e = exp_q.pop_front();
        chk({mrg_index, mrg_bits} == e, "R4 merge word", {29'd0, mrg_index, mrg_bits}, {29'd0, e});
      end
    end
  end

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    desc_rd_addr = a;
    #1;
    v = desc_rd_data;
  endtask

  task automatic post(input logic [7:0] v);
    @(negedge clk);
    post_valid = 1'b1; post_vector = v;
    @(negedge clk);
    post_valid = 1'b0;
    #2;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    desc_wr_en = 1'b1; desc_wr_addr = a; desc_wr_data = d;
    @(negedge clk);
    desc_wr_en = 1'b0;
    #2;
  endtask

  task automatic push_words(input logic [31:0] w0, w1, w2, w3, w4, w5, w6, w7);
    exp_q.push_back({3'd0, w0}); exp_q.push_back({3'd1, w1});
    exp_q.push_back({3'd2, w2}); exp_q.push_back({3'd3, w3});
    exp_q.push_back({3'd4, w4}); exp_q.push_back({3'd5, w5});
    exp_q.push_back({3'd6, w6}); exp_q.push_back({3'd7, w7});
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #2;
      if (!mrg_valid) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: reset state
    begin
      logic [31:0] acc = '0;
      for (int a = 0; a < 16; a++) begin rd(a[3:0], rd_v); acc |= rd_v; end
      chk(acc == 0, "R1 descriptor zero", acc, 0);
    end
    chk(!mrg_valid && !irq_out_valid && !notify_req && post_ready, "R1 outputs idle",
        {mrg_valid, irq_out_valid, notify_req, post_ready}, 4'b0001);

    // R2/R3: first post raises the flag and notifies
    post(8'd3);
    chk(notify_req == 1'b1, "R3 first post notifies", notify_req, 1);
    rd(4'd0, rd_v); chk(rd_v == 32'h8, "R2 word0 bit3", rd_v, 32'h8);
    rd(4'd8, rd_v); chk(rd_v == 32'h1, "R2 flag set", rd_v, 1);
    post(8'd200);
    chk(notify_req == 1'b0, "R3 no repeat notify", notify_req, 0);
    rd(4'd6, rd_v); chk(rd_v == 32'h100, "R2 word6 bit8", rd_v, 32'h100);
    post(8'd255);
    rd(4'd7, rd_v); chk(rd_v == 32'h8000_0000, "R2 word7 bit31", rd_v, 32'h8000_0000);

    // R4/R5/R10: matching notification while running
    push_words(32'h8, 0, 0, 0, 0, 0, 32'h100, 32'h8000_0000);
    @(negedge clk);
    irq_in_valid = 1'b1; irq_in_vector = NV;
    #2;
    chk(irq_in_ready == 1'b1 && !irq_out_valid, "R4 notification accepted", {irq_in_ready, irq_out_valid}, 2'b10);
    @(negedge clk); #2;
    chk(mrg_valid && irq_in_ready == 1'b0, "R10 busy blocks notification", {mrg_valid, irq_in_ready}, 2'b10);
    rd(4'd8, rd_v); chk(rd_v == 0, "R4 flag cleared", rd_v, 0);
    irq_in_valid = 1'b0;
    wait_idle();
    chk(exp_q.size() == 0, "R4 all words merged", exp_q.size(), 0);
    begin
      logic [31:0] acc = '0;
      for (int a = 0; a < 8; a++) begin rd(a[3:0], rd_v); acc |= rd_v; end
      chk(acc == 0, "R5 bitmap cleared", acc, 0);
    end

    // R6/R7: back-pressure with posts landing mid-sweep
    post(8'd33);
    post(8'd100);
    push_words(32'h0, 32'h102, 0, 32'h10, 0, 0, 0, 0);
    @(negedge clk);
    mrg_ready = 1'b0; irq_in_valid = 1'b1; irq_in_vector = NV;
    @(negedge clk);
    irq_in_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      #2;
      chk(mrg_valid && mrg_index == 3'd0, "R6 stall holds index", {mrg_valid, mrg_index}, 4'b1000);
      @(negedge clk);
    end
    mrg_ready = 1'b1; post_valid = 1'b1; post_vector = 8'd5;
    @(negedge clk);
    mrg_ready = 1'b0; post_vector = 8'd40;
    #2;
    chk(notify_req == 1'b1, "R3 notify after flag cleared", notify_req, 1);
    chk(mrg_index == 3'd1, "R6 advance on handshake", mrg_index, 1);
    @(negedge clk);
    post_valid = 1'b0; mrg_ready = 1'b1;
    wait_idle();
    chk(exp_q.size() == 0, "R7 sweep drained", exp_q.size(), 0);
    rd(4'd0, rd_v); chk(rd_v == 32'h20, "R7 post behind sweep kept", rd_v, 32'h20);
    rd(4'd1, rd_v); chk(rd_v == 32'h0, "R7 post ahead captured", rd_v, 0);
    rd(4'd8, rd_v); chk(rd_v == 32'h1, "R7 flag set by late post", rd_v, 1);

    // R8: deferred while not running
    @(negedge clk);
    vcpu_running = 1'b0; irq_in_valid = 1'b1; irq_in_vector = NV;
    #2;
    chk(irq_in_ready == 1'b1, "R8 accepted while stopped", irq_in_ready, 1);
    @(negedge clk);
    irq_in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    chk(!mrg_valid, "R8 no sweep while stopped", mrg_valid, 0);
    rd(4'd8, rd_v); chk(rd_v == 32'h1, "R8 flag untouched", rd_v, 1);
    rd(4'd0, rd_v); chk(rd_v == 32'h20, "R8 bitmap untouched", rd_v, 32'h20);
    push_words(32'h20, 0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    vcpu_running = 1'b1;
    @(negedge clk); #2;
    chk(mrg_valid == 1'b1, "R8 sweep on resume", mrg_valid, 1);
    wait_idle();
    chk(exp_q.size() == 0, "R8 deferred merge done", exp_q.size(), 0);
    rd(4'd8, rd_v); chk(rd_v == 0, "R8 flag cleared", rd_v, 0);

    // R9: foreign vector passes through
    post(8'd7);
    @(negedge clk);
    irq_in_valid = 1'b1; irq_in_vector = 8'h31; irq_out_ready = 1'b0;
    #2;
    chk(irq_out_valid && irq_out_vector == 8'h31 && !irq_in_ready, "R9 pass with back-pressure",
        {irq_out_valid, irq_out_vector, irq_in_ready}, {1'b1, 8'h31, 1'b0});
    @(negedge clk);
    irq_out_ready = 1'b1;
    #2;
    chk(irq_in_ready == 1'b1, "R9 ready follows pass ready", irq_in_ready, 1);
    @(negedge clk);
    irq_in_valid = 1'b0;
    @(negedge clk); #2;
    chk(!mrg_valid, "R9 no sweep", mrg_valid, 0);
    rd(4'd8, rd_v); chk(rd_v == 32'h1, "R9 flag kept", rd_v, 1);
    rd(4'd0, rd_v); chk(rd_v == 32'h80, "R9 bitmap kept", rd_v, 32'h80);

    // R11: descriptor writes and reserved space
    wr(4'd8, 32'hFFFF_FFFE);
    rd(4'd8, rd_v); chk(rd_v == 0, "R11 word8 bit0 cleared", rd_v, 0);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd8, rd_v); chk(rd_v == 32'h1, "R11 word8 reserved dropped", rd_v, 1);
    wr(4'd12, 32'hDEAD_BEEF);
    rd(4'd12, rd_v); chk(rd_v == 0, "R11 reserved word zero", rd_v, 0);
    wr(4'd2, 32'h1234_5678);
    rd(4'd2, rd_v); chk(rd_v == 32'h1234_5678, "R11 bitmap word write", rd_v, 32'h1234_5678);

    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule